// File: doc/BRIEF.md
# Buffered UART frame transmitter

This block is a transmit-only serial port for a chip that emits short fixed-length messages. A producer hands it bytes one at a time. The block collects them in an internal FIFO. As soon as a whole frame of `FRAME_LEN` bytes is waiting, the block sends the frame on a single serial line. Each byte goes out as a standard asynchronous character with one start bit, eight data bits and one stop bit, and there is no gap between characters. An enable output for a half-duplex line driver brackets the burst.

The bit rate is set while running by a 32-bit frequency word. On every clock that word is added into a 32-bit phase accumulator. Each carry out of the accumulator is one timing tick, and one bit period lasts `TICKS_PER_BIT` ticks. A word of W therefore gives a bit period of `TICKS_PER_BIT * 2^32 / W` clocks. The rate can be any fraction of the clock, and single bits jitter by at most one clock.

The byte input uses a valid/ready pair. `in_ready` is high whenever the FIFO has a free slot. A byte counts as accepted on a clock edge where both `in_valid` and `in_ready` are high. The producer is expected to hold back while `in_ready` is low. If it asserts `in_valid` anyway, the byte is discarded and a sticky overflow flag is raised. The FIFO holds `2^ceil(log2(2*FRAME_LEN))` bytes, which is 16 for the default frame length of 5.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `drv_en` is 0, `overflow` is 0 and `in_ready` is 1.
- R2: Each byte is sent as a start bit of 0, then the eight data bits least significant bit first, then a stop bit of 1.
- R3: One bit lasts `TICKS_PER_BIT` (default 32) accumulator carries, where a carry occurs whenever adding `freq_word` into the 32-bit accumulator overflows. A frame of n bytes spans `n*10*TICKS_PER_BIT*2^32/freq_word` clocks, within one clock.
- R4: No frame starts while fewer than `FRAME_LEN` bytes are buffered. Bytes left over from a previous burst wait until the count is reached again.
- R5: The bytes of a frame leave in arrival order, with each start bit following the previous stop bit directly. The distance from one start edge to the next is 10 bit periods, within one clock.
- R6: `drv_en` rises exactly one bit period before the first start bit and falls when the last stop bit ends. While `drv_en` is 0, `tx_line` is 1.
- R7: `in_ready` is 0 while the FIFO is full. A byte offered then is dropped and never transmitted, and `overflow` becomes 1 and stays 1 until reset.
- R8: A byte accepted on the same clock edge as a byte is taken out for transmission is stored. Neither the byte going in nor the byte coming out is lost or repeated.
- R9: With `freq_word` = 143936068 and a 110 MHz clock, the measured character rate corresponds to 115200 baud within 0.2 %.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| freq_word | input | 32 | Phase increment added to the accumulator on every clock |
| in_valid | input | 1 | Producer offers `in_data` this cycle |
| in_data | input | 8 | Byte to buffer |
| in_ready | output | 1 | FIFO has room; the byte is taken when valid and ready are both high |
| tx_line | output | 1 | Serial output, idles at 1 |
| drv_en | output | 1 | Line-driver enable covering the transmit window |
| overflow | output | 1 | Sticky: a byte was offered while the FIFO was full |

## Verification
The case most likely to break is a producer write that lands on the same clock edge as the transmitter pulling its next byte out of the FIFO. On that edge the level counter has to be raised and lowered at once. The bench waits for the first start edge of a frame, adds exactly ten bit periods, and offers one byte so that it is sampled on the clock where the second character is loaded. The byte is judged correct if, after four further writes, the next frame begins with it, and the frame in flight keeps all five bytes in order without duplication.

// File: rtl/uftx_pkg.sv
package uftx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SEND
  } tx_state_e;

  localparam int CHAR_BITS = 10;
  localparam int DATA_BITS = 8;
endpackage

// File: rtl/uftx_fifo.sv
module uftx_fifo #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   level,
  output logic          full,
  output logic          empty,
  output logic          overflow
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          ovf_q;
  logic          wr_en;

  assign full     = (cnt == FULL_LVL);
  assign empty    = (cnt == '0);
  assign wr_en    = wr_req && !full;
  assign rd_data  = mem[rp];
  assign level    = cnt;
  assign overflow = ovf_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (wr_req && full) ovf_q <= 1'b1;
    end
  end

  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !rd_en) |=> $stable(cnt)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R7
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty); // R5
  AST_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> $stable(cnt)); // R8
endmodule

// File: rtl/uftx_baud.sv
module uftx_baud #(
  parameter int ACC_W = 32,
  parameter int TICKS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq_word,
  output logic             bit_stb
);
  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TICKS - 1);

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;
  logic             tick;
  logic [TW-1:0]    tcnt;

  assign sum     = {1'b0, acc} + {1'b0, freq_word};
  assign tick    = sum[ACC_W];
  assign bit_stb = tick && (tcnt == TLAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      tcnt <= '0;
    end else begin
      acc <= sum[ACC_W-1:0];
      if (tick) tcnt <= (tcnt == TLAST) ? '0 : tcnt + 1'b1;
    end
  end

  AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb); // R3
endmodule

// File: rtl/uftx_shifter.sv
module uftx_shifter
  import uftx_pkg::*;
#(
  parameter int FRAME_LEN = 5,
  parameter int LW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_stb,
  input  logic [LW-1:0] level,
  input  logic [7:0]    rd_data,
  output logic          rd_en,
  output logic          tx_line,
  output logic          drv_en
);
  localparam int FCW = $clog2(FRAME_LEN + 1);
  localparam logic [LW-1:0]  FL_LVL   = LW'(FRAME_LEN);
  localparam logic [FCW-1:0] FL_CNT   = FCW'(FRAME_LEN);
  localparam logic [3:0]     LAST_BIT = 4'(CHAR_BITS - 1);

  tx_state_e            state;
  logic [CHAR_BITS-1:0] shreg;
  logic [3:0]           bit_idx;
  logic [FCW-1:0]       left;
  logic                 tx_q, en_q;
  logic                 load;

  assign load    = bit_stb && ((state == ST_LEAD) ||
                   (state == ST_SEND && bit_idx == LAST_BIT && left != '0));
  assign rd_en   = load;
  assign tx_line = tx_q;
  assign drv_en  = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '1;
      bit_idx <= '0;
      left    <= '0;
      tx_q    <= 1'b1;
      en_q    <= 1'b0;
    end else if (bit_stb) begin
      if (load) begin
        shreg   <= {1'b1, rd_data, 1'b0};
        tx_q    <= 1'b0;
        bit_idx <= '0;
        left    <= left - 1'b1;
        state   <= ST_SEND;
      end else begin
        case (state)
          ST_IDLE: begin
            if (level >= FL_LVL) begin
              state <= ST_LEAD;
              en_q  <= 1'b1;
              left  <= FL_CNT;
            end
          end
          ST_SEND: begin
            if (bit_idx == LAST_BIT) begin
              state <= ST_IDLE;
              en_q  <= 1'b0;
              tx_q  <= 1'b1;
            end else begin
              shreg   <= {1'b1, shreg[CHAR_BITS-1:1]};
              tx_q    <= shreg[1];
              bit_idx <= bit_idx + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_LINE_HIGH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> tx_q); // R6
  AST_START_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> ($past(level) >= FL_LVL)); // R4
  AST_EN_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_q) |-> $past(en_q)); // R6
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int FRAME_LEN     = 5,
  parameter int TICKS_PER_BIT = 32,
  parameter int ACC_W         = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq_word,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             tx_line,
  output logic             drv_en,
  output logic             overflow
);
  localparam int FIFO_AW = $clog2(2 * FRAME_LEN);
  localparam int LW      = FIFO_AW + 1;

  logic          bit_stb;
  logic          rd_en;
  logic [7:0]    rd_data;
  logic [LW-1:0] level;
  logic          full, empty;

  assign in_ready = !full;

  uftx_baud #(.ACC_W(ACC_W), .TICKS(TICKS_PER_BIT)) u_baud (
    .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .bit_stb(bit_stb)
  );

  uftx_fifo #(.DW(8), .AW(FIFO_AW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_req(in_valid), .wr_data(in_data),
    .rd_en(rd_en), .rd_data(rd_data), .level(level), .full(full),
    .empty(empty), .overflow(overflow)
  );

  uftx_shifter #(.FRAME_LEN(FRAME_LEN), .LW(LW)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .level(level),
    .rd_data(rd_data), .rd_en(rd_en), .tx_line(tx_line), .drv_en(drv_en)
  );

  AST_READY_WHILE_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !in_ready) |-> 1'b0); // R1
endmodule

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/1ps
module uart_frame_tx_tb;
  localparam int FL = 5;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fw = 32'h8000_0000;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  wire         in_ready, tx_line, drv_en, overflow;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  int fs = 0;
  bit fs_valid = 1'b0;
  int frame_clks = 0;
  logic [7:0] model[$];

  uart_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .freq_word(fw), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .tx_line(tx_line),
    .drv_en(drv_en), .overflow(overflow)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic real rabs(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  function automatic logic [7:0] pat(input int i);
    if (i < 8) return 8'(1 << i);
    if (i < 16) return ~8'(1 << (i - 8));
    case (i)
      16: return 8'h00;
      17: return 8'hFF;
      18: return 8'h55;
      19: return 8'hAA;
      default: return 8'((i * 37 + 11) % 256);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wr_one(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    model.push_back(d);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wr_burst(input int base, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = pat(base + i);
      model.push_back(pat(base + i));
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle_hold(input int n, input string req);
    bit ok = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (drv_en || !tx_line) ok = 1'b0;
    end
    chk(ok, req, "no transmission expected", drv_en, 0);
  endtask

  task automatic rx_frame(input real p, input int n);
    int t_en, ts, t0, te, tn;
    logic [9:0] b;
    logic [7:0] e;
    fs_valid = 1'b0;
    while (!drv_en) @(negedge clk);
    t_en = cyc;
    while (tx_line) @(negedge clk);
    ts = cyc; t0 = ts; fs = ts; fs_valid = 1'b1;
    chk(rabs(real'(ts - t_en) - p) <= 1.0, "R6", "enable lead", ts - t_en, $rtoi(p));
    for (int k = 0; k < n; k++) begin
      if (k > 0) begin
        while (tx_line) @(negedge clk);
        tn = cyc;
        chk(rabs(real'(tn - ts) - 10.0 * p) <= 1.0, "R5", "char spacing", tn - ts, $rtoi(10.0 * p));
        ts = tn;
      end
      for (int i = 0; i < 10; i++) begin
        wait_cyc(ts + $rtoi((real'(i) + 0.5) * p));
        b[i] = tx_line;
      end
      e = (model.size() > 0) ? model.pop_front() : 8'hxx;
      chk(b[0] == 1'b0, "R2", "start bit", b[0], 0);
      chk(b[9] == 1'b1, "R2", "stop bit", b[9], 1);
      chk(b[8:1] == e, "R2", "data byte (R5 order)", b[8:1], e);
      chk(drv_en == 1'b1, "R6", "enable held", drv_en, 1);
    end
    while (drv_en) @(negedge clk);
    te = cyc;
    chk(rabs(real'(te - ts) - 10.0 * p) <= 1.0, "R6", "enable fall", te - ts, $rtoi(10.0 * p));
    chk(tx_line == 1'b1, "R6", "line idle after frame", tx_line, 1);
    frame_clks = te - t0;
    chk(rabs(real'(frame_clks) - real'(n) * 10.0 * p) <= 1.0, "R3", "frame length",
        frame_clks, $rtoi(real'(n) * 10.0 * p));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    model.delete();
    repeat (4) @(negedge clk);
    chk(tx_line == 1'b1, "R1", "tx idle", tx_line, 1);
    chk(drv_en == 1'b0, "R1", "enable low", drv_en, 0);
    chk(overflow == 1'b0, "R1", "overflow clear", overflow, 0);
    chk(in_ready == 1'b1, "R1", "ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    real p;
    fw = 32'h8000_0000;
    p = 64.0;
    do_reset();

    // R4: four bytes are not enough
    wr_burst(100, FL - 1);
    idle_hold(20 * 64, "R4");
    wr_burst(104, 1);
    rx_frame(p, FL);

    // R2/R5 pattern sweep, ten frames
    for (int f = 0; f < 10; f++) begin
      wr_burst(f * FL, FL);
      rx_frame(p, FL);
    end

    // R4: leftovers wait for a full frame
    wr_burst(60, FL + 2);
    rx_frame(p, FL);
    idle_hold(3 * 64, "R4");
    wr_burst(67, FL - 2);
    rx_frame(p, FL);

    // R8: write on the exact edge of the second character load
    wr_burst(80, FL);
    fork
      rx_frame(p, FL);
      begin
        while (!fs_valid) @(negedge clk);
        wait_cyc(fs + 10 * 64 - 1);
        in_valid = 1'b1;
        in_data  = 8'hC3;
        model.push_back(8'hC3);
        @(negedge clk);
        in_valid = 1'b0;
      end
    join
    wr_burst(90, FL - 1);
    rx_frame(p, FL);

    // R7: seventeen back-to-back writes into a sixteen-entry FIFO
    for (int i = 0; i < DEPTH + 1; i++) begin
      @(negedge clk);
      chk(in_ready == (i < DEPTH), "R7", "ready vs fill", in_ready, (i < DEPTH));
      in_valid = 1'b1;
      in_data  = pat(120 + i);
      if (i < DEPTH) model.push_back(pat(120 + i));
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(overflow == 1'b1, "R7", "overflow set", overflow, 1);
    for (int f = 0; f < 3; f++) rx_frame(p, FL);
    chk(overflow == 1'b1, "R7", "overflow sticky", overflow, 1);
    wr_burst(200, FL - 1);
    rx_frame(p, FL);
    chk(model.size() == 0, "R7", "dropped byte never sent", model.size(), 0);
    chk(overflow == 1'b1, "R7", "overflow still set", overflow, 1);
    do_reset();

    // R3: fractional word, 85.33 clocks per bit
    fw = 32'd1610612736;
    p = 32.0 * 4294967296.0 / 1610612736.0;
    wr_burst(30, FL);
    rx_frame(p, FL);

    // R9: 115200 baud word at a 110 MHz clock
    fw = 32'd143936068;
    p = 32.0 * 4294967296.0 / 143936068.0;
    wr_burst(40, FL);
    rx_frame(p, FL);
    begin
      real baud;
      baud = 110.0e6 * real'(FL * 10) / real'(frame_clks);
      chk(rabs(baud - 115200.0) <= 0.002 * 115200.0, "R9", "baud rate",
          $rtoi(baud), 115200);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1..all: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule